// File: doc/BRIEF.md
# SPI Configuration Register Loader

This block is a write-only SPI slave that loads five 8-bit configuration registers for a pseudo-random sequence generator. The registers hold the clock divider setting, the sequence repeat count, the data-bit count, the bit-enable mask and the feedback polynomial. The SPI pins are sampled into the system clock domain through two-flop synchronisers. Each chip-select session carries a command byte followed by one data byte. The command byte names the target register.

A debug input overrides the whole map. While it is high, the outputs present fixed preset values and SPI writes are locked out. The stored contents stay as they were and reappear when debug drops. An active-low reset clears every stored register to zero.

Top module: `spi_cfg_regfile`

## Requirements
- R1: The SPI link is mode 0 and most significant bit first. Bits are taken on rising SCK edges while chip select is low. A command byte carries a marker in bit 7, which must be 1, and a register address in bits 2:0. Bits 6:3 of the command byte are ignored.
- R2: Address 1 selects the divider, 2 the sequence count, 3 the data-bit count, 4 the bit-enable mask and 5 the polynomial.
- R3: The byte after a valid command is stored in the addressed register. The register keeps that value until it is rewritten or reset.
- R4: If the command byte has bit 7 at 0, or its address is 0, 6 or 7, the data byte of that session changes no register.
- R5: At most one register is written per chip-select session. Bytes after the data byte are ignored, and a data byte is never decoded as a command, even when its bit 7 is 1.
- R6: Raising chip select discards any command or partial byte in progress. A session that ends before eight data bits have arrived writes nothing.
- R7: While rstN is low, all five registers are cleared to 0x00.
- R8: While debugMode is high, the outputs show the presets: divider 0x03, sequence count 0x07, data-bit count 0x07, mask 0x0F, polynomial 0x0C.
- R9: While debugMode is high, SPI writes leave the stored registers unchanged. The values held before debug reappear when debug goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| debugMode | input | 1 | Forces preset outputs and blocks writes |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSck | input | 1 | SPI serial clock |
| spiMosi | input | 1 | SPI serial data in |
| divCfg | output | 8 | Clock divider register |
| seqCountCfg | output | 8 | Sequence repeat count register |
| bitCountCfg | output | 8 | Data-bit count register |
| enMaskCfg | output | 8 | Bit-enable mask register |
| polyCfg | output | 8 | Feedback polynomial register |

## Verification
The hardest cases to reach from the ports are those where the decoder state must hold out against misleading traffic. Examples are a data byte with the marker bit set that must not be taken as a command, a third byte in a session, and a session cut off after half a data byte. The stimulus builds these from raw bit-level SPI sessions. It sends three-byte sessions, sends truncated sessions, and follows each truncated session with a clean one, so that any leftover state would show in the next write. The debug lock is checked by writing during debug and reading the stored value back once debug drops.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 5;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int MARK_BIT = BYTE_W - 1;

  // presets packed with register 1 in the low byte
  localparam logic [NUM_REGS*BYTE_W-1:0] PRESET_DEFAULT = {8'h0C, 8'h0F, 8'h07, 8'h07, 8'h03};

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [BYTE_W-1:0] wrData;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_DATA = 2'd1,
    ST_DONE = 2'd2
  } sessState_t;
endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      spiCsN,
  input  logic      spiSck,
  input  logic      spiMosi,
  output logic      csIdle,
  output wrStrobe_t stb
);
  logic [1:0]        csPipe, sckPipe, mosiPipe;
  logic              sckLast;
  logic              sckRise;
  logic [BYTE_W-2:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] cmdHold;
  logic [BYTE_W-1:0] newByte;
  logic              byteDone;
  logic              cmdOk;
  sessState_t        state;

  // two-flop synchronisers; chip select idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sckPipe  <= '0;
      mosiPipe <= '0;
      sckLast  <= 1'b0;
    end else begin
      csPipe   <= {csPipe[0], spiCsN};
      sckPipe  <= {sckPipe[0], spiSck};
      mosiPipe <= {mosiPipe[0], spiMosi};
      sckLast  <= sckPipe[1];
    end
  end

  assign csIdle   = csPipe[1];
  assign sckRise  = !csIdle && sckPipe[1] && !sckLast;
  assign newByte  = {shiftReg, mosiPipe[1]};
  assign byteDone = sckRise && (bitCnt == CNT_W'(BYTE_W - 1));
  assign cmdOk    = newByte[MARK_BIT] &&
                    (newByte[ADDR_W-1:0] >= ADDR_W'(1)) &&
                    (newByte[ADDR_W-1:0] <= ADDR_W'(NUM_REGS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      shiftReg <= '0;
      bitCnt   <= '0;
      cmdHold  <= '0;
    end else if (csIdle) begin
      state    <= ST_CMD;
      shiftReg <= '0;
      bitCnt   <= '0;
      cmdHold  <= '0;
    end else if (sckRise) begin
      shiftReg <= newByte[BYTE_W-2:0];
      bitCnt   <= bitCnt + 1'b1;
      if (byteDone) begin
        unique case (state)
          ST_CMD: begin
            cmdHold <= newByte;
            state   <= cmdOk ? ST_DATA : ST_DONE;
          end
          ST_DATA: state <= ST_DONE;
          default: state <= ST_DONE;
        endcase
      end
    end
  end

  always_comb begin
    stb.wrEn   = byteDone && (state == ST_DATA);
    stb.wrAddr = cmdHold[ADDR_W-1:0];
    stb.wrData = newByte;
  end
endmodule

// File: rtl/spi_cfg_datapath.sv
module spi_cfg_datapath
  import spi_cfg_pkg::*;
#(
  parameter logic [NUM_REGS*BYTE_W-1:0] PRESETS = PRESET_DEFAULT
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             debugMode,
  input  wrStrobe_t                        stb,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  stored,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  cfgOut
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g + 1);
    logic hit;
    assign hit = stb.wrEn && !debugMode && (stb.wrAddr == MY_ADDR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    stored[g] <= '0;
      else if (hit) stored[g] <= stb.wrData;
    end

    assign cfgOut[g] = debugMode ? PRESETS[g*BYTE_W +: BYTE_W] : stored[g];
  end
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter logic [NUM_REGS*BYTE_W-1:0] PRESETS = PRESET_DEFAULT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              debugMode,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiMosi,
  output logic [BYTE_W-1:0] divCfg,
  output logic [BYTE_W-1:0] seqCountCfg,
  output logic [BYTE_W-1:0] bitCountCfg,
  output logic [BYTE_W-1:0] enMaskCfg,
  output logic [BYTE_W-1:0] polyCfg
);
  wrStrobe_t                      stb;
  logic                           csIdle;
  logic [NUM_REGS-1:0][BYTE_W-1:0] stored;
  logic [NUM_REGS-1:0][BYTE_W-1:0] cfgOut;

  spi_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck),
    .spiMosi(spiMosi), .csIdle(csIdle), .stb(stb)
  );

  spi_cfg_datapath #(.PRESETS(PRESETS)) u_dp (
    .clk(clk), .rstN(rstN), .debugMode(debugMode), .stb(stb),
    .stored(stored), .cfgOut(cfgOut)
  );

  assign divCfg      = cfgOut[0];
  assign seqCountCfg = cfgOut[1];
  assign bitCountCfg = cfgOut[2];
  assign enMaskCfg   = cfgOut[3];
  assign polyCfg     = cfgOut[4];
endmodule

// File: rtl/spi_cfg_regfile_chk.sv
module spi_cfg_regfile_chk
  import spi_cfg_pkg::*;
#(
  parameter logic [NUM_REGS*BYTE_W-1:0] PRESETS = PRESET_DEFAULT
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             debugMode,
  input logic                             csIdle,
  input wrStrobe_t                        stb,
  input logic [NUM_REGS-1:0][BYTE_W-1:0]  stored,
  input logic [NUM_REGS-1:0][BYTE_W-1:0]  cfgOut
);
  logic sessionWrote;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sessionWrote <= 1'b0;
    else if (csIdle)    sessionWrote <= 1'b0;
    else if (stb.wrEn)  sessionWrote <= 1'b1;
  end

  AST_WR_ADDR_IN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (stb.wrAddr >= ADDR_W'(1) && stb.wrAddr <= ADDR_W'(NUM_REGS))); // R4
  AST_ONE_WR_PER_SESSION: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> !sessionWrote); // R5
  AST_NO_WR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |-> !stb.wrEn); // R6
  AST_HOLD_WITHOUT_WR: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(stored)); // R3
  AST_DEBUG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |=> $stable(stored)); // R9
  AST_DEBUG_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> (cfgOut == PRESETS)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rstN) |-> (stored == '0)); // R7
endmodule

bind spi_cfg_regfile spi_cfg_regfile_chk #(.PRESETS(PRESETS)) u_chk (
  .clk(clk), .rstN(rstN), .debugMode(debugMode), .csIdle(csIdle),
  .stb(stb), .stored(stored), .cfgOut(cfgOut)
);

// File: tb/spi_cfg_regfile_tb.sv
module spi_cfg_regfile_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic debugMode = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSck = 1'b0;
  logic spiMosi = 1'b0;
  logic [7:0] divCfg, seqCountCfg, bitCountCfg, enMaskCfg, polyCfg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  spi_cfg_regfile u_dut (
    .clk(clk), .rstN(rstN), .debugMode(debugMode), .spiCsN(spiCsN),
    .spiSck(spiSck), .spiMosi(spiMosi), .divCfg(divCfg),
    .seqCountCfg(seqCountCfg), .bitCountCfg(bitCountCfg),
    .enMaskCfg(enMaskCfg), .polyCfg(polyCfg)
  );

  // {cmd, data, expected div, seq, bits, mask, poly}
  localparam int NVEC = 10;
  localparam logic [55:0] VECS [NVEC] = '{
    {8'h81, 8'h03, 40'h03_00_00_00_00},  // R1 R2 R3
    {8'h82, 8'h14, 40'h03_14_00_00_00},  // R2
    {8'h83, 8'hA5, 40'h03_14_A5_00_00},  // R2
    {8'h84, 8'h1F, 40'h03_14_A5_1F_00},  // R2
    {8'h85, 8'h1C, 40'h03_14_A5_1F_1C},  // R2
    {8'h01, 8'h55, 40'h03_14_A5_1F_1C},  // R4 no marker
    {8'h86, 8'h77, 40'h03_14_A5_1F_1C},  // R4 addr 6
    {8'h80, 8'h99, 40'h03_14_A5_1F_1C},  // R4 addr 0
    {8'hF9, 8'h42, 40'h42_14_A5_1F_1C},  // R1 bits 6:3 ignored
    {8'h87, 8'h11, 40'h42_14_A5_1F_1C}   // R4 addr 7
  };

  function automatic logic [39:0] regsNow();
    return {divCfg, seqCountCfg, bitCountCfg, enMaskCfg, polyCfg};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spiMosi = b[i];
      waitClk(4);
      spiSck = 1'b1;
      waitClk(4);
      spiSck = 1'b0;
    end
  endtask

  task automatic beginSess();
    spiCsN = 1'b0;
    waitClk(4);
  endtask

  task automatic endSess();
    waitClk(4);
    spiCsN = 1'b1;
    waitClk(8);
  endtask

  task automatic writeReg(input logic [7:0] cmd, input logic [7:0] data);
    beginSess();
    sendBits(cmd, 8);
    sendBits(data, 8);
    endSess();
  endtask

  initial begin
    waitClk(200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    check("R7 reset state", regsNow(), 40'h0);
    rstN = 1'b1;
    waitClk(2);
    check("R7 after release", regsNow(), 40'h0);

    for (int v = 0; v < NVEC; v++) begin
      writeReg(VECS[v][55:48], VECS[v][47:40]);
      check($sformatf("R3 vector %0d", v), regsNow(), VECS[v][39:0]);
    end

    // R5: third byte ignored
    beginSess();
    sendBits(8'h83, 8); sendBits(8'h3C, 8); sendBits(8'h84, 8); sendBits(8'h0F, 8);
    endSess();
    check("R5 extra bytes", regsNow(), 40'h42_14_3C_1F_1C);

    // R5: data byte with marker is stored, not decoded
    writeReg(8'h85, 8'h81);
    check("R5 data with marker", regsNow(), 40'h42_14_3C_1F_81);

    // R6: truncated data byte writes nothing
    beginSess();
    sendBits(8'h82, 8); sendBits(8'hF0, 4);
    endSess();
    check("R6 truncated session", regsNow(), 40'h42_14_3C_1F_81);

    // R6: truncated command then a clean session
    beginSess();
    sendBits(8'h84, 5);
    endSess();
    writeReg(8'h82, 8'h66);
    check("R6 clean after cut", regsNow(), 40'h42_66_3C_1F_81);

    // R8 / R9: debug presets and lock
    debugMode = 1'b1;
    waitClk(2);
    check("R8 presets", regsNow(), 40'h03_07_07_0F_0C);
    writeReg(8'h81, 8'hEE);
    check("R8 presets held", regsNow(), 40'h03_07_07_0F_0C);
    debugMode = 1'b0;
    waitClk(2);
    check("R9 stored unchanged", regsNow(), 40'h42_66_3C_1F_81);

    // R7: reset in operation
    rstN = 1'b0;
    waitClk(2);
    check("R7 reset clears", regsNow(), 40'h0);
    rstN = 1'b1;
    waitClk(2);
    writeReg(8'h84, 8'h3F);
    check("R2 mask after reset", regsNow(), 40'h00_00_00_3F_00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule